// File: doc/BRIEF.md
# Single-Wire Slave Time-Slot Engine

This block is the bit-level engine of a slave on a single open-drain bus line. It watches a synchronised copy of the line, measures every low period against a 1 MHz tick, and works out from each one whether the master has written a bit, opened a read slot or issued a bus reset. It answers each reset with a presence pulse. It can also raise a long interrupt pulse on its own, which is followed by a presence pulse. The line is driven only through a pull-down enable, so the bus stays a wired-AND.

An upper layer exchanges bits with the engine through strobes. Each received bit is reported with a one-cycle `rxValid`. A bit to send is offered on `txValid`/`txBit` before the master opens the slot, and the engine confirms it with `txTaken` once that slot is over. A detected reset is reported with `resetSeen`.

Top module: `swire_slot_engine`

## Requirements
- R1: After reset, `pullDown`, `rxValid`, `txTaken` and `resetSeen` are all 0, and the line is left released until the master first pulls it low.
- R2: When `txValid` is 0 at the falling edge, the slot is a write slot. The received bit is the line level 30 µs after the falling edge (high = 1, low = 0). It is reported by one `rxValid` pulse, with the bit on `rxBit`, once the line is high again and at least 30 µs have passed since the falling edge.
- R3: When `txValid` is 1 at the falling edge, the slot is a read slot. If `txBit` is 0, the engine holds the line low until 30 µs after the falling edge. If `txBit` is 1, it never pulls the line low in that slot. Either kind of read slot ends with one `txTaken` pulse and no `rxValid`.
- R4: A low period of 480 µs or more is a bus reset. It produces one `resetSeen` pulse when the line is released, and no `rxValid` or `txTaken`.
- R5: After a reset, the presence pulse starts 30 µs after the line is released and holds the line low for 120 µs.
- R6: A pulse on `irqReq` while the line is idle and high makes the engine drive the line low for `IRQ_LOW_US` µs (960 to 3840, default 1000). It then releases the line and sends a presence pulse with the timing of R5.
- R7: A low period just under the reset threshold (for example 470 µs) is decoded as a write-zero slot, not as a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-cycle pulse once per microsecond |
| lineIn | input | 1 | Synchronised bus level, 1 = high |
| pullDown | output | 1 | 1 = pull the open-drain bus low |
| rxValid | output | 1 | One-cycle strobe: a received bit is on rxBit |
| rxBit | output | 1 | Last received bit |
| txValid | input | 1 | The next slot is a read slot that sends txBit |
| txBit | input | 1 | Bit to send in the next read slot |
| txTaken | output | 1 | One-cycle strobe: a read slot has completed |
| irqReq | input | 1 | One-cycle request for an interrupt pulse |
| resetSeen | output | 1 | One-cycle strobe: a bus reset was detected |

## Verification
The assertions take for granted that `lineIn` is already synchronised to `clk`, that `tickUs` is a single-cycle pulse, and that the master keeps at least 1 µs of recovery, so the line stays high for a clock after any slot ends. They also assume `txValid`/`txBit` are settled before the master's falling edge, and that the master does not pull the line low during a presence or interrupt pulse. The bench models the bus as the wired-AND of the master's pull and `pullDown`. It changes inputs only on falling clock edges, waits whole microseconds with full recovery between slots, and offers a transmit bit only before it opens a read slot.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_PRES_WAIT,
    ST_PRESENCE,
    ST_IRQ
  } slotState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic slotStart;
    logic rxCapture;
  } dpCtrl_t;

  // timing flags from datapath to control
  typedef struct packed {
    logic sampleTick;
    logic atSample;
    logic resetLen;
    logic presWaitDone;
    logic presDone;
    logic irqDone;
    logic readZeroHold;
    logic slotIsRead;
  } dpFlags_t;

endpackage

// File: rtl/swire_datapath.sv
module swire_datapath
  import swire_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int SAMPLE_US    = 30,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_US      = 120,
  parameter int IRQ_LOW_US   = 1000,
  parameter int READ_HOLD_US = 30
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickUs,
  input  logic     lineIn,
  input  logic     txValid,
  input  logic     txBit,
  input  dpCtrl_t  ctrl,
  output dpFlags_t flags,
  output logic     rxBit
);

  localparam logic [CNT_W-1:0] CNT_MAX       = '1;
  localparam logic [CNT_W-1:0] SAMPLE_PRE    = CNT_W'(SAMPLE_US - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LIM    = CNT_W'(SAMPLE_US);
  localparam logic [CNT_W-1:0] RESET_LIM     = CNT_W'(RESET_US);
  localparam logic [CNT_W-1:0] PRES_WAIT_LIM = CNT_W'(PRES_WAIT_US);
  localparam logic [CNT_W-1:0] PRES_LIM      = CNT_W'(PRES_US);
  localparam logic [CNT_W-1:0] IRQ_LIM       = CNT_W'(IRQ_LOW_US);
  localparam logic [CNT_W-1:0] HOLD_LIM      = CNT_W'(READ_HOLD_US);

  logic [CNT_W-1:0] usCnt;
  logic             isReadQ;
  logic             txBitQ;
  logic             rxBitQ;

  // microsecond counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      usCnt <= '0;
    end else if (ctrl.cntClr) begin
      usCnt <= '0;
    end else if (tickUs && usCnt != CNT_MAX) begin
      usCnt <= usCnt + 1'b1;
    end
  end

  // slot kind and transmit bit latched at the falling edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isReadQ <= 1'b0;
      txBitQ  <= 1'b1;
    end else if (ctrl.slotStart) begin
      isReadQ <= txValid;
      txBitQ  <= txBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBitQ <= 1'b0;
    end else if (ctrl.rxCapture) begin
      rxBitQ <= lineIn;
    end
  end

  always_comb begin
    flags.sampleTick   = tickUs && (usCnt == SAMPLE_PRE);
    flags.atSample     = usCnt >= SAMPLE_LIM;
    flags.resetLen     = usCnt >= RESET_LIM;
    flags.presWaitDone = usCnt >= PRES_WAIT_LIM;
    flags.presDone     = usCnt >= PRES_LIM;
    flags.irqDone      = usCnt >= IRQ_LIM;
    flags.readZeroHold = isReadQ && !txBitQ && (usCnt < HOLD_LIM);
    flags.slotIsRead   = isReadQ;
  end

  assign rxBit = rxBitQ;

  // R2: a bit is only captured in a write slot
  a_r2_capture_write_only: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rxCapture |-> !isReadQ);

endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineIn,
  input  logic     irqReq,
  input  dpFlags_t flags,
  output dpCtrl_t  ctrl,
  output logic     pullDown,
  output logic     rxValid,
  output logic     txTaken,
  output logic     resetSeen
);

  slotState_t state, stateNext;
  logic irqPend;
  logic irqStart;
  logic rxNext, txNext, rstNext;

  always_comb begin
    stateNext      = state;
    ctrl.cntClr    = 1'b0;
    ctrl.slotStart = 1'b0;
    ctrl.rxCapture = 1'b0;
    irqStart       = 1'b0;
    rxNext         = 1'b0;
    txNext         = 1'b0;
    rstNext        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!lineIn) begin
          stateNext      = ST_SLOT;
          ctrl.cntClr    = 1'b1;
          ctrl.slotStart = 1'b1;
        end else if (irqPend) begin
          stateNext   = ST_IRQ;
          ctrl.cntClr = 1'b1;
          irqStart    = 1'b1;
        end
      end
      ST_SLOT: begin
        ctrl.rxCapture = flags.sampleTick && !flags.slotIsRead;
        if (flags.atSample && lineIn) begin
          if (flags.resetLen) begin
            stateNext   = ST_PRES_WAIT;
            ctrl.cntClr = 1'b1;
            rstNext     = 1'b1;
          end else begin
            stateNext = ST_IDLE;
            txNext    = flags.slotIsRead;
            rxNext    = !flags.slotIsRead;
          end
        end
      end
      ST_PRES_WAIT: begin
        if (flags.presWaitDone) begin
          stateNext   = ST_PRESENCE;
          ctrl.cntClr = 1'b1;
        end
      end
      ST_PRESENCE: begin
        if (flags.presDone) stateNext = ST_IDLE;
      end
      ST_IRQ: begin
        if (flags.irqDone) begin
          stateNext   = ST_PRES_WAIT;
          ctrl.cntClr = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      irqPend   <= 1'b0;
      rxValid   <= 1'b0;
      txTaken   <= 1'b0;
      resetSeen <= 1'b0;
    end else begin
      state     <= stateNext;
      irqPend   <= irqReq | (irqPend & ~irqStart);
      rxValid   <= rxNext;
      txTaken   <= txNext;
      resetSeen <= rstNext;
    end
  end

  assign pullDown = (state == ST_PRESENCE) || (state == ST_IRQ) ||
                    ((state == ST_SLOT) && flags.readZeroHold);

  // R2: a bit is reported only after the line has come back high
  a_r2_rx_after_release: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(lineIn));
  // R2: one report per slot
  a_r2_rx_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  // R3: a finished read slot leaves the line released
  a_r3_tx_released: assert property (@(posedge clk) disable iff (!rstN)
    txTaken |-> !pullDown);
  // R4: a reset is never also reported as a bit
  a_r4_reset_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    resetSeen |-> (!rxValid && !txTaken));
  // R5: presence is delayed after the reset release
  a_r5_presence_delay: assert property (@(posedge clk) disable iff (!rstN)
    resetSeen |-> !pullDown);

endmodule

// File: rtl/swire_slot_engine.sv
module swire_slot_engine
  import swire_pkg::*;
#(
  parameter int SAMPLE_US    = 30,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_US      = 120,
  parameter int IRQ_LOW_US   = 1000,
  parameter int READ_HOLD_US = 30
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickUs,
  input  logic lineIn,
  output logic pullDown,
  output logic rxValid,
  output logic rxBit,
  input  logic txValid,
  input  logic txBit,
  output logic txTaken,
  input  logic irqReq,
  output logic resetSeen
);

  localparam int LIMIT_US = ((IRQ_LOW_US > RESET_US) ? IRQ_LOW_US : RESET_US) + 1;
  localparam int CNT_W    = $clog2(LIMIT_US + 1);

  dpCtrl_t  dpCtrl;
  dpFlags_t dpFlags;

  swire_datapath #(
    .CNT_W       (CNT_W),
    .SAMPLE_US   (SAMPLE_US),
    .RESET_US    (RESET_US),
    .PRES_WAIT_US(PRES_WAIT_US),
    .PRES_US     (PRES_US),
    .IRQ_LOW_US  (IRQ_LOW_US),
    .READ_HOLD_US(READ_HOLD_US)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .tickUs (tickUs),
    .lineIn (lineIn),
    .txValid(txValid),
    .txBit  (txBit),
    .ctrl   (dpCtrl),
    .flags  (dpFlags),
    .rxBit  (rxBit)
  );

  swire_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .irqReq   (irqReq),
    .flags    (dpFlags),
    .ctrl     (dpCtrl),
    .pullDown (pullDown),
    .rxValid  (rxValid),
    .txTaken  (txTaken),
    .resetSeen(resetSeen)
  );

endmodule

// File: tb/swire_slot_engine_tb.sv
module swire_slot_engine_tb;

  localparam int TICK_DIV = 5;
  localparam int IRQ_US   = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 1'b0;
  logic masterLow = 1'b0;
  logic lineIn;
  logic pullDown, rxValid, rxBit, txTaken, resetSeen;
  logic txValid = 1'b0;
  logic txBit = 1'b1;
  logic irqReq = 1'b0;

  int checks = 0;
  int errors = 0;
  int rxCnt = 0, txCnt = 0, rstCnt = 0;
  logic rxLast = 1'b0;
  int tickDiv = 0;
  bit finished = 0;

  // vector: {isRead, txBit, expected bit, low time in us (13 bits)}
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 13'd5},
    {1'b0, 1'b0, 1'b0, 13'd70},
    {1'b1, 1'b0, 1'b0, 13'd2},
    {1'b0, 1'b0, 1'b1, 13'd1},
    {1'b1, 1'b1, 1'b1, 13'd2},
    {1'b0, 1'b0, 1'b0, 13'd110},
    {1'b0, 1'b0, 1'b1, 13'd14},
    {1'b1, 1'b0, 1'b0, 13'd3}
  };

  always #10 clk = ~clk;

  assign lineIn = ~(masterLow | pullDown);

  swire_slot_engine #(.IRQ_LOW_US(IRQ_US)) u_dut (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .lineIn(lineIn),
    .pullDown(pullDown), .rxValid(rxValid), .rxBit(rxBit),
    .txValid(txValid), .txBit(txBit), .txTaken(txTaken),
    .irqReq(irqReq), .resetSeen(resetSeen)
  );

  always @(negedge clk) begin
    tickDiv <= (tickDiv == TICK_DIV - 1) ? 0 : tickDiv + 1;
    tickUs  <= (tickDiv == TICK_DIV - 1);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin rxCnt++; rxLast = rxBit; end
      if (txTaken) txCnt++;
      if (resetSeen) rstCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitUs(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic busReset(input int lowUs);
    masterLow = 1'b1;
    waitUs(lowUs);
    masterLow = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rx0, tx0, r0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pullDown == 1'b0, "R1 pullDown", pullDown, 0);
    check(rxValid == 1'b0 && txTaken == 1'b0 && resetSeen == 1'b0, "R1 strobes",
          {rxValid, txTaken, resetSeen}, 0);
    waitUs(10);
    check(lineIn == 1'b1, "R1 line released", lineIn, 1);

    // vector table of slots
    for (int i = 0; i < NVEC; i++) begin
      rx0 = rxCnt; tx0 = txCnt;
      if (VEC[i][15]) begin
        txValid = 1'b1; txBit = VEC[i][14];
        @(negedge clk);
        masterLow = 1'b1;
        waitUs(VEC[i][12:0]);
        masterLow = 1'b0;
        waitUs(15 - VEC[i][12:0]);
        check(lineIn == VEC[i][13], "R3 read bit level", lineIn, VEC[i][13]);
        txValid = 1'b0;
        waitUs(40);
        check(lineIn == 1'b1, "R3 released after hold", lineIn, 1);
        waitUs(70);
        check(txCnt == tx0 + 1 && rxCnt == rx0, "R3 txTaken once", txCnt - tx0, 1);
      end else begin
        masterLow = 1'b1;
        waitUs(VEC[i][12:0]);
        masterLow = 1'b0;
        waitUs(125 - VEC[i][12:0]);
        check(rxCnt == rx0 + 1 && txCnt == tx0, "R2 rxValid once", rxCnt - rx0, 1);
        check(rxLast == VEC[i][13], "R2 received bit", rxLast, VEC[i][13]);
      end
    end

    // R4 / R5 bus reset and presence
    rx0 = rxCnt; r0 = rstCnt;
    busReset(500);
    waitUs(15);
    check(lineIn == 1'b1, "R5 gap before presence", lineIn, 1);
    check(rstCnt == r0 + 1, "R4 resetSeen once", rstCnt - r0, 1);
    check(rxCnt == rx0, "R4 no bit for reset", rxCnt - rx0, 0);
    waitUs(45);
    check(pullDown == 1'b1, "R5 presence active", pullDown, 1);
    waitUs(80);
    check(pullDown == 1'b1, "R5 presence late", pullDown, 1);
    waitUs(40);
    check(pullDown == 1'b0, "R5 presence ended", pullDown, 0);
    waitUs(20);

    // R7 just under the reset threshold
    rx0 = rxCnt; r0 = rstCnt;
    busReset(470);
    waitUs(60);
    check(rstCnt == r0, "R7 no reset at 470us", rstCnt - r0, 0);
    check(rxCnt == rx0 + 1 && rxLast == 1'b0, "R7 decoded as zero", rxLast, 0);
    check(pullDown == 1'b0, "R7 no presence", pullDown, 0);
    waitUs(150);
    check(pullDown == 1'b0, "R7 still no presence", pullDown, 0);

    // R6 spontaneous interrupt
    @(negedge clk);
    irqReq = 1'b1;
    @(negedge clk);
    irqReq = 1'b0;
    waitUs(500);
    check(pullDown == 1'b1, "R6 interrupt low", pullDown, 1);
    waitUs(IRQ_US - 500 - 5);
    check(pullDown == 1'b1, "R6 interrupt near end", pullDown, 1);
    waitUs(20);
    check(lineIn == 1'b1, "R6 released before presence", lineIn, 1);
    waitUs(45);
    check(pullDown == 1'b1, "R6 presence after interrupt", pullDown, 1);
    waitUs(140);
    check(pullDown == 1'b0, "R6 presence ended", pullDown, 0);

    // R2 slot after interrupt still decodes
    rx0 = rxCnt;
    busReset(3);
    waitUs(122);
    check(rxCnt == rx0 + 1 && rxLast == 1'b1, "R2 slot after interrupt", rxLast, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule